// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a synchronous serial master driven from a simple 32-bit register bus. Software picks a frame width of 1 to 16 bits, sets a clock divider and pushes words into an 8-deep transmit queue. While the port is enabled, each queued word is shifted out MSB first on `sclk`/`mosi` in SPI mode 0. The bits seen on `miso` are collected into an 8-deep receive queue, which software drains through the same data register.

Flow control is built in. A frame starts only when a transmit word is waiting and the receive queue has a free slot. A full receive queue therefore pauses the link instead of losing data. Status flags report queue levels. Two threshold interrupts, receive at half full and transmit at half empty, are masked and merged into one level `irq`. A loopback switch sends the serial output straight back to the sampler. A read-only window at the top of the map returns eight identification bytes.

Top module: `spm_top`

## Requirements
- R1: After synchronous reset both queues are empty, status (0x0C) reads 0x03, raw interrupts (0x18) read 0x08, the mask (0x14) reads 0, and `irq` and `sclk` are low.
- R2: Control 0 (0x00) keeps bits [3:0] as F, and the frame is F+1 bits. A word written to the data register (0x08) is ANDed with the width in force at write time. A captured word is ANDed with the width in force when it completes.
- R3: Control 1 (0x04) bit 0 selects loopback. In loopback the value on `mosi` is sampled in place of `miso`, so each received word equals the sent word, whatever `miso` does.
- R4: A frame is shifted MSB first in mode 0. `sclk` idles low, `mosi` changes only at frame start or on a falling `sclk`, and `miso` is sampled on the rising `sclk`.
- R5: Control 1 bit 1 enables the port. While it is clear no frame starts and queued words wait.
- R6: Status bits: [0] transmit queue empty, [1] transmit queue not full, [2] receive queue not empty, [3] receive queue full, [4] busy (transmit queue not empty or a frame in flight).
- R7: Raw bit 2 is set when the receive queue holds 4 or more words. Raw bit 3 is set when the transmit queue holds 4 or fewer. 0x1C reads raw AND mask, and `irq` is high one cycle after that AND is nonzero.
- R8: No frame starts while the receive queue holds 8 words. Reading the data register frees a slot, transfer resumes, and words stay in order.
- R9: A data write while the transmit queue holds 8 words is dropped. A data read while the receive queue is empty returns 0.
- R10: The prescaler (0x10) keeps its low 8 bits as P. `sclk` holds each level for 2*P clocks, or 4 clocks when P is 0. 0x20 reads 0.
- R11: Reads of 0xFE0, 0xFE4, ... 0xFFC return 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; reading the data register pops the receive queue |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 16-bit data path and 8-deep queues. With these defaults every frame width from 1 to 16 can be swept in loopback. Both queues can be driven to their limits in a few hundred cycles, and the interrupt thresholds of 4 sit in the middle of the range. A behavioural slave on the serial pins checks bit order and sampling edges against arithmetic expectations. Two divider settings, including the zero case, are timed directly on `sclk`.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 12'h000;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 12'h004;
  localparam logic [ADDR_W-1:0] A_DATA  = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_PSC   = 12'h010;
  localparam logic [ADDR_W-1:0] A_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] A_RAW   = 12'h018;
  localparam logic [ADDR_W-1:0] A_MIS   = 12'h01C;
  localparam logic [ADDR_W-1:0] A_DMA   = 12'h020;
  localparam logic [ADDR_W-1:0] A_IDWIN = 12'hFE0;

  // control 1 bit positions
  localparam int C1_LOOP = 0;
  localparam int C1_EN   = 1;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h22;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/spm_fifo.sv
module spm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                pdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH):0]       count
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/spm_shifter.sv
module spm_shifter #(
  parameter int DW  = 16,
  parameter int FSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [DW-1:0]  word,
  input  logic [FSW-1:0] fsel,
  input  logic [7:0]     psc,
  input  logic           loop,
  input  logic           miso,
  output logic           active,
  output logic           sclk,
  output logic           mosi,
  output logic           done,
  output logic [DW-1:0]  rx_word
);
  logic [DW-1:0] txsh, rxsh;
  logic [FSW:0]  left;
  logic [8:0]    div, half;
  logic          sample;

  assign half   = (psc == 8'd0) ? 9'd4 : {psc, 1'b0};
  assign sample = loop ? txsh[DW-1] : miso;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      done   <= 1'b0;
      txsh   <= '0;
      rxsh   <= '0;
      left   <= '0;
      div    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        txsh   <= word << (FSW'(DW-1) - fsel);
        rxsh   <= '0;
        left   <= {1'b0, fsel} + 1'b1;
        div    <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (div == half - 9'd1) begin
          div <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rxsh <= {rxsh[DW-2:0], sample};
          end else begin
            sclk <= 1'b0;
            if (left == 1) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              left <= left - 1'b1;
              txsh <= txsh << 1;
            end
          end
        end else begin
          div <= div + 9'd1;
        end
      end
    end
  end

  assign mosi    = txsh[DW-1];
  assign rx_word = rxsh;
endmodule

// File: rtl/spm_top.sv
module spm_top
  import spm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int FSW  = $clog2(DW);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  logic [FSW-1:0] cr0_fs;
  logic [3:0]     cr1;
  logic [7:0]     psc;
  logic [3:0]     imask;
  logic [DW-1:0]  fmask;

  logic [DW-1:0]  tx_head, rx_head, rx_word;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           tx_push, tx_pop, rx_push, rx_pop;
  logic           active, done, start;
  logic           tx_empty, tx_full, rx_empty, rx_full;
  logic [3:0]     raw;
  logic [4:0]     stat;
  logic [31:0]    rd_next;

  assign fmask    = {DW{1'b1}} >> (FSW'(DW-1) - cr0_fs);
  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));

  assign tx_push = bus_wr && (bus_addr == A_DATA) && !tx_full;
  assign rx_pop  = bus_rd && (bus_addr == A_DATA) && !rx_empty;
  assign start   = cr1[C1_EN] && !active && !done && !tx_empty && !rx_full;
  assign tx_pop  = start;
  assign rx_push = done;

  spm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .pdata(bus_wdata[DW-1:0] & fmask),
    .pop(tx_pop), .head(tx_head), .count(tx_cnt));

  spm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pdata(rx_word & fmask),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt));

  spm_shifter #(.DW(DW), .FSW(FSW)) u_shift (
    .clk(clk), .rst(rst), .start(start), .word(tx_head), .fsel(cr0_fs),
    .psc(psc), .loop(cr1[C1_LOOP]), .miso(miso), .active(active),
    .sclk(sclk), .mosi(mosi), .done(done), .rx_word(rx_word));

  assign raw  = {(tx_cnt <= CW'(HALF)), (rx_cnt >= CW'(HALF)), 2'b00};
  assign stat = {(!tx_empty || active), rx_full, !rx_empty, !tx_full, tx_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0_fs <= '0;
      cr1    <= '0;
      psc    <= '0;
      imask  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL0: cr0_fs <= bus_wdata[FSW-1:0];
        A_CTRL1: cr1    <= bus_wdata[3:0];
        A_PSC:   psc    <= bus_wdata[7:0];
        A_MASK:  imask  <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr >= A_IDWIN) begin
      rd_next = {24'd0, id_byte(bus_addr[4:2])};
    end else begin
      case (bus_addr)
        A_CTRL0: rd_next = 32'(cr0_fs);
        A_CTRL1: rd_next = 32'(cr1);
        A_DATA:  rd_next = rx_empty ? 32'd0 : 32'(rx_head);
        A_STAT:  rd_next = 32'(stat);
        A_PSC:   rd_next = 32'(psc);
        A_MASK:  rd_next = 32'(imask);
        A_RAW:   rd_next = 32'(raw);
        A_MIS:   rd_next = 32'(raw & imask);
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      irq <= |(raw & imask);
    end
  end
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          active,
  input logic          start,
  input logic          sclk,
  input logic          mosi,
  input logic [3:0]    cr1,
  input logic [3:0]    imask,
  input logic          irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  a_r9_tx_bound: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= FULL);

  a_r8_rx_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= FULL);

  a_r8_start_room: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> ($past(rx_cnt) < FULL) && ($past(tx_cnt) != '0));

  a_r5_start_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(cr1[1]));

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);

  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> ($fell(sclk) || $rose(active)));

  a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == FULL) && !start |=> tx_cnt == FULL);

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(((rx_cnt >= HALF) && imask[2]) ||
                          ((tx_cnt <= HALF) && imask[3])));
endmodule

bind spm_top spm_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .active(active),
  .start(start), .sclk(sclk), .mosi(mosi), .cr1(cr1), .imask(imask),
  .irq(irq));

// File: tb/sim_spm_top.sv
`timescale 1ns/1ps
module sim_spm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi, miso;

  int checks = 0;
  int fails  = 0;
  logic [15:0] slv = '0;
  logic [15:0] cap = '0;

  always #2.5 clk = ~clk;

  spm_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso));

  // behavioural mode-0 slave
  assign miso = slv[15];
  always @(negedge sclk) slv <= slv << 1;
  always @(posedge sclk) cap <= {cap[14:0], mosi};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(12'h00C, s);
      if (s[4] == 1'b0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (sclk !== 1'b1) @(negedge clk);
    while (sclk === 1'b1) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] w, m;
    int n;
    logic [7:0] idexp [8];
    idexp = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 / R6 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    rd(12'h00C, d); chk("R1 R6 status", d, 32'h03);
    rd(12'h018, d); chk("R1 raw", d, 32'h08);
    rd(12'h014, d); chk("R1 mask", d, 32'h0);

    // R11 identification window
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i), d);
      chk("R11 id", d, {24'd0, idexp[i]});
    end

    // R10 prescaler width, DMA reads 0; R9 empty read
    wr(12'h010, 32'h1FF); rd(12'h010, d); chk("R10 psc", d, 32'hFF);
    rd(12'h020, d); chk("R10 dma", d, 32'h0);
    rd(12'h008, d); chk("R9 empty read", d, 32'h0);

    // R5 disabled port holds words
    wr(12'h010, 32'h1);
    wr(12'h000, 32'h7);
    wr(12'h004, 32'h1);
    wr(12'h008, 32'h1A5);
    repeat (200) @(negedge clk);
    rd(12'h00C, d); chk("R5 held status", d, 32'h12);
    wr(12'h004, 32'h3);
    wait_idle();
    rd(12'h008, d); chk("R5 R2 after enable", d, 32'hA5);

    // R2 / R3 sweep every frame width in loopback, miso driven opposite
    for (int f = 0; f < 16; f++) begin
      m = 16'hFFFF >> (15 - f);
      wr(12'h000, 32'(f));
      for (int p = 0; p < 3; p++) begin
        w = (p == 0) ? 16'hFFFF : (p == 1) ? 16'hA5C3 : 16'(16'h1357 * (f + 3));
        slv = ~(w << (15 - f));
        wr(12'h008, {16'd0, w});
        wait_idle();
        rd(12'h008, d);
        chk("R2 R3 loopback width", d, {16'd0, w & m});
      end
    end

    // R2 masking at entry and at capture
    wr(12'h004, 32'h1);
    wr(12'h000, 32'h3); wr(12'h008, 32'hFFFF);
    wr(12'h000, 32'hF); wr(12'h004, 32'h3);
    wait_idle(); rd(12'h008, d); chk("R2 entry mask", d, 32'h000F);
    wr(12'h004, 32'h1);
    wr(12'h008, 32'hABCD); wr(12'h000, 32'h3); wr(12'h004, 32'h3);
    wait_idle(); rd(12'h008, d); chk("R2 capture mask", d, 32'h000D);

    // R4 external slave, MSB first
    wr(12'h004, 32'h2);
    wr(12'h000, 32'h7);
    slv = 16'h5A00; cap = '0;
    wr(12'h008, 32'hC3);
    wait_idle(); rd(12'h008, d);
    chk("R4 rx 8b", d, 32'h5A);
    chk("R4 tx 8b", {24'd0, cap[7:0]}, 32'hC3);
    wr(12'h000, 32'hB);
    slv = 16'h9E10; cap = '0;
    wr(12'h008, 32'h3B7);
    wait_idle(); rd(12'h008, d);
    chk("R4 rx 12b", d, 32'h9E1);
    chk("R4 tx 12b", {20'd0, cap[11:0]}, 32'h3B7);

    // R10 half-period timing
    wr(12'h000, 32'h7);
    wr(12'h010, 32'h3);
    wr(12'h008, 32'h55);
    measure(n); chk("R10 half period psc3", 32'(n), 32'd6);
    wait_idle(); rd(12'h008, d);
    wr(12'h010, 32'h0);
    wr(12'h008, 32'h55);
    measure(n); chk("R10 half period psc0", 32'(n), 32'd4);
    wait_idle(); rd(12'h008, d);

    // R8 / R9 stall on full receive queue and drop on full transmit queue
    wr(12'h010, 32'h1);
    wr(12'h004, 32'h1);
    for (int i = 0; i < 9; i++) wr(12'h008, 32'(i));
    rd(12'h00C, d); chk("R9 R6 tx full status", d, 32'h10);
    rd(12'h018, d); chk("R7 raw tx full", d, 32'h0);
    wr(12'h004, 32'h3);
    repeat (400) @(negedge clk);
    rd(12'h00C, d); chk("R8 R6 rx full status", d, 32'h0F);
    rd(12'h018, d); chk("R7 raw rx full", d, 32'h0C);
    wr(12'h008, 32'h80); wr(12'h008, 32'h81); wr(12'h008, 32'h82);
    repeat (300) @(negedge clk);
    rd(12'h00C, d); chk("R8 stalled status", d, 32'h1E);
    for (int i = 0; i < 11; i++) begin
      rd(12'h008, d);
      chk("R8 R9 order", d, (i < 8) ? 32'(i) : 32'(8'h80 + i - 8));
      repeat (100) @(negedge clk);
    end
    rd(12'h00C, d); chk("R8 drained status", d, 32'h03);

    // R7 interrupts
    wr(12'h014, 32'hC);
    repeat (3) @(negedge clk);
    chk("R7 irq tx low", {31'd0, irq}, 32'd1);
    rd(12'h01C, d); chk("R7 masked", d, 32'h08);
    wr(12'h004, 32'h1);
    for (int i = 0; i < 5; i++) wr(12'h008, 32'(i + 16));
    repeat (3) @(negedge clk);
    chk("R7 irq off", {31'd0, irq}, 32'd0);
    wr(12'h014, 32'h4);
    wr(12'h004, 32'h3);
    wait_idle();
    chk("R7 irq rx half", {31'd0, irq}, 32'd1);
    rd(12'h018, d); chk("R7 raw both", d, 32'h0C);
    rd(12'h01C, d); chk("R7 masked rx", d, 32'h04);
    rd(12'h008, d); rd(12'h008, d);
    repeat (3) @(negedge clk);
    chk("R7 irq rx low", {31'd0, irq}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule